// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Unit

This block holds eight single-bit token latches that two independent ports (left and right) use to reserve shared resources. The latches are separate from any main memory. A port requests a token by writing 0 to it and releases it, or withdraws a waiting request, by writing 1. Only bit 0 of the write data matters. A read returns the port's own view of the token, copied onto every data bit: 0 means "this port holds it" and 1 means "free or held by the other side".

Each port can reach a token only when its semaphore select is low and its memory chip enable is high. A request written by one side while the other side holds the token is remembered. It turns into ownership on the same clock edge that records the holder's release. When both sides request a free token in the same cycle, the left port takes it and the right port's request is kept as waiting. All activity is sampled on the rising clock edge, and read data is captured into a per-port output register.

Top module: `sem_token_unit`

## Requirements
- R1: After the synchronous active-low reset, all eight tokens are free, no request is waiting, and both read-data registers hold all ones.
- R2: A port reaches the tokens only when its select is low and its chip enable is high. With both low, or with the select high, a write changes no token and a read leaves that port's read data unchanged.
- R3: Address bits [2:0] pick one of the eight tokens. All higher address bits are ignored.
- R4: A write uses only data bit 0 (0 = request, 1 = release or cancel). All other data bits are ignored.
- R5: A free token reads 1 on both ports. Once one port owns it, that port reads 0 and the other port reads 1. Both ports never read 0 for the same token.
- R6: Only the owner can change a token. A 0 written by the non-owner changes neither port's reading, and a 1 written by the non-owner gives it no ownership.
- R7: If the non-owner has written 0 while the other side owns the token, it becomes owner on the same edge that takes in the owner's write of 1.
- R8: A 1 written by a waiting non-owner cancels its request, so a later release by the owner leaves the token free.
- R9: When both ports request a free token in the same cycle, the left port becomes owner and the right port's request is kept as waiting.
- R10: A read loads the port's view of the addressed token onto every bit of its read-data register. The view is taken before any write on the same edge. The register holds until that port's next valid read.
- R11: The eight tokens are independent. An operation on one token never changes another token.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| l_sel_n | input | 1 | Left semaphore select, active low |
| l_ce_n | input | 1 | Left memory chip enable, active low (must be high for token access) |
| l_wr | input | 1 | Left write strobe |
| l_rd | input | 1 | Left read strobe |
| l_addr | input | ADDR_W | Left address; bits [2:0] pick the token |
| l_wdata | input | DATA_W | Left write data; bit 0 used |
| l_rdata | output | DATA_W | Left captured read data |
| r_sel_n | input | 1 | Right semaphore select, active low |
| r_ce_n | input | 1 | Right memory chip enable, active low (must be high for token access) |
| r_wr | input | 1 | Right write strobe |
| r_rd | input | 1 | Right read strobe |
| r_addr | input | ADDR_W | Right address; bits [2:0] pick the token |
| r_wdata | input | DATA_W | Right write data; bit 0 used |
| r_rdata | output | DATA_W | Right captured read data |

## Verification
Two things can land on the same clock edge. The first is that both ports write to the same token. The bench provokes this with a joint request on a free token and expects the left side to win and the right side to gain the token as soon as the left releases it. The second is that one port reads a token while the other port's write changes it. The bench has the right port read while the left owner releases with the right request waiting, and it expects the captured value to be the view from before the edge, with the new ownership showing only on the next read.

// File: rtl/sem_token_pkg.sv
// Shared constants and types for the two-port semaphore unit.
// Assumes exactly eight tokens, picked by the low three address bits.
package sem_token_pkg;
    localparam int TOK_COUNT = 8;
    localparam int TOK_IDX_W = $clog2(TOK_COUNT);

    // Who currently holds a token.
    typedef enum logic [1:0] {
        TOK_FREE  = 2'd0,
        TOK_LEFT  = 2'd1,
        TOK_RIGHT = 2'd2
    } tok_owner_e;

    // One port's decoded request for the current cycle.
    typedef struct packed {
        logic                 wr_ok;
        logic                 rd_ok;
        logic [TOK_IDX_W-1:0] idx;
        logic                 wbit;
    } port_req_t;
endpackage

// File: rtl/sem_port_decode.sv
// Qualifies one port's strobes and splits them into a per-token write
// vector. Assumes select and chip enable are active low and that token
// access requires select low with chip enable high.
module sem_port_decode
    import sem_token_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 16
) (
    input  logic              sel_n,
    input  logic              ce_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output port_req_t         req,
    output logic [TOK_COUNT-1:0] wr_hot
);
    logic access_ok;

    // Decide whether this cycle is a legal token access and build the request.
    always_comb begin
        access_ok  = !sel_n && ce_n;
        req.wr_ok  = access_ok && wr;
        req.rd_ok  = access_ok && rd;
        req.idx    = addr[TOK_IDX_W-1:0];
        req.wbit   = wdata[0];
    end

    // Expand the write into a one-hot vector across the tokens.
    generate
        for (genvar t = 0; t < TOK_COUNT; t++) begin : g_hot
            assign wr_hot[t] = req.wr_ok && (req.idx == TOK_IDX_W'(t));
        end
    endgenerate
endmodule

// File: rtl/sem_token_cell.sv
// One token latch: tracks the owner and a waiting request per side.
// A waiting request turns into ownership on the edge of the owner's release.
// Simultaneous requests on a free token favour the left side.
module sem_token_cell
    import sem_token_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic l_wr,
    input  logic l_bit,
    input  logic r_wr,
    input  logic r_bit,
    output logic held_l,
    output logic held_r
);
    tok_owner_e own_q, own_d;
    logic       wait_l_q, wait_l_d;
    logic       wait_r_q, wait_r_d;
    logic       l_req, l_rel, r_req, r_rel;
    logic       wait_l_upd, wait_r_upd;

    // Classify this cycle's writes from each side.
    always_comb begin
        l_req = l_wr && !l_bit;
        l_rel = l_wr &&  l_bit;
        r_req = r_wr && !r_bit;
        r_rel = r_wr &&  r_bit;
    end

    // Waiting flags updated by each side's own write (request sets, release clears).
    always_comb begin
        wait_l_upd = l_req ? 1'b1 : (l_rel ? 1'b0 : wait_l_q);
        wait_r_upd = r_req ? 1'b1 : (r_rel ? 1'b0 : wait_r_q);
    end

    // Next owner and waiting state.
    always_comb begin
        own_d    = own_q;
        wait_l_d = 1'b0;
        wait_r_d = 1'b0;
        unique case (own_q)
            TOK_FREE: begin
                if (l_req) begin
                    own_d    = TOK_LEFT;
                    wait_r_d = r_req;
                end else if (r_req) begin
                    own_d = TOK_RIGHT;
                end
            end
            TOK_LEFT: begin
                if (l_rel) begin
                    own_d = wait_r_upd ? TOK_RIGHT : TOK_FREE;
                end else begin
                    wait_r_d = wait_r_upd;
                end
            end
            TOK_RIGHT: begin
                if (r_rel) begin
                    own_d = wait_l_upd ? TOK_LEFT : TOK_FREE;
                end else begin
                    wait_l_d = wait_l_upd;
                end
            end
            default: own_d = TOK_FREE;
        endcase
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q    <= TOK_FREE;
            wait_l_q <= 1'b0;
            wait_r_q <= 1'b0;
        end else begin
            own_q    <= own_d;
            wait_l_q <= wait_l_d;
            wait_r_q <= wait_r_d;
        end
    end

    // Ownership flags seen by the read paths.
    always_comb begin
        held_l = (own_q == TOK_LEFT);
        held_r = (own_q == TOK_RIGHT);
    end
endmodule

// File: rtl/sem_read_capture.sv
// Per-port read register: on a valid read it loads the port's view of the
// addressed token onto every data bit and holds it until the next read.
// Assumes the view is 0 when this port owns the token and 1 otherwise.
module sem_read_capture
    import sem_token_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  port_req_t            req,
    input  logic [TOK_COUNT-1:0] view,
    output logic [DATA_W-1:0]    rdata
);
    // Capture the selected view, replicated across the data width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '1;
        end else if (req.rd_ok) begin
            rdata <= {DATA_W{view[req.idx]}};
        end
    end
endmodule

// File: rtl/sem_token_unit.sv
// Two-port semaphore unit: eight token latches shared by a left and a right
// port, with per-port decode and captured read data. All ports are sampled
// on the rising edge of clk; reset is synchronous and active low.
module sem_token_unit
    import sem_token_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_sel_n,
    input  logic              l_ce_n,
    input  logic              l_wr,
    input  logic              l_rd,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_sel_n,
    input  logic              r_ce_n,
    input  logic              r_wr,
    input  logic              r_rd,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);
    port_req_t            l_req, r_req;
    logic [TOK_COUNT-1:0] l_hot, r_hot;
    logic [TOK_COUNT-1:0] held_l, held_r;
    logic [TOK_COUNT-1:0] view_l, view_r;

    sem_port_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_l (
        .sel_n(l_sel_n), .ce_n(l_ce_n), .wr(l_wr), .rd(l_rd),
        .addr(l_addr), .wdata(l_wdata), .req(l_req), .wr_hot(l_hot)
    );

    sem_port_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_r (
        .sel_n(r_sel_n), .ce_n(r_ce_n), .wr(r_wr), .rd(r_rd),
        .addr(r_addr), .wdata(r_wdata), .req(r_req), .wr_hot(r_hot)
    );

    generate
        for (genvar t = 0; t < TOK_COUNT; t++) begin : g_tok
            sem_token_cell u_cell (
                .clk(clk), .rst_n(rst_n),
                .l_wr(l_hot[t]), .l_bit(l_req.wbit),
                .r_wr(r_hot[t]), .r_bit(r_req.wbit),
                .held_l(held_l[t]), .held_r(held_r[t])
            );
        end
    endgenerate

    // Each side reads 0 only for tokens it owns.
    always_comb begin
        view_l = ~held_l;
        view_r = ~held_r;
    end

    sem_read_capture #(.DATA_W(DATA_W)) u_cap_l (
        .clk(clk), .rst_n(rst_n), .req(l_req), .view(view_l), .rdata(l_rdata)
    );

    sem_read_capture #(.DATA_W(DATA_W)) u_cap_r (
        .clk(clk), .rst_n(rst_n), .req(r_req), .view(view_r), .rdata(r_rdata)
    );
endmodule

// File: rtl/sem_token_unit_chk.sv
// Property checker for the semaphore unit, attached by bind. Watches the
// ports and the per-token ownership flags of the top module.
module sem_token_unit_chk
    import sem_token_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 l_sel_n,
    input logic                 l_ce_n,
    input logic                 l_wr,
    input logic                 l_rd,
    input logic [ADDR_W-1:0]    l_addr,
    input logic [DATA_W-1:0]    l_rdata,
    input logic                 r_sel_n,
    input logic                 r_ce_n,
    input logic                 r_wr,
    input logic                 r_rd,
    input logic [ADDR_W-1:0]    r_addr,
    input logic [DATA_W-1:0]    r_rdata,
    input logic [TOK_COUNT-1:0] held_l,
    input logic [TOK_COUNT-1:0] held_r
);
    logic l_rd_ok, r_rd_ok, l_wr_ok, r_wr_ok;
    assign l_rd_ok = !l_sel_n && l_ce_n && l_rd;
    assign r_rd_ok = !r_sel_n && r_ce_n && r_rd;
    assign l_wr_ok = !l_sel_n && l_ce_n && l_wr;
    assign r_wr_ok = !r_sel_n && r_ce_n && r_wr;

    // R1: reset leaves every token unowned.
    assert_reset_free_R1: assert property (@(posedge clk)
        !rst_n |=> (held_l == '0 && held_r == '0));

    // R2 / R10: without a valid read the captured data holds.
    assert_left_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !l_rd_ok |=> $stable(l_rdata));
    assert_right_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !r_rd_ok |=> $stable(r_rdata));

    // R10: read data is a replicated single bit.
    assert_replicated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (l_rdata == '0 || l_rdata == '1) && (r_rdata == '0 || r_rdata == '1));

    // R5: never owned by both sides.
    assert_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (held_l & held_r) == '0);

    // R5: joint reads of one token never both report ownership.
    assert_joint_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (l_rd_ok && r_rd_ok && l_addr[TOK_IDX_W-1:0] == r_addr[TOK_IDX_W-1:0])
        |=> (l_rdata[0] || r_rdata[0]));

    // R6: ownership only moves after a valid write.
    assert_owner_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(l_wr_ok || r_wr_ok) |=> ($stable(held_l) && $stable(held_r)));
endmodule

bind sem_token_unit sem_token_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sem_token_unit_bench.sv
// Directed bench for the semaphore unit: one task per scenario.
module sem_token_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 14;
    localparam int DATA_W = 16;
    localparam logic [DATA_W-1:0] ONES = '1;
    localparam logic [DATA_W-1:0] ZERO = '0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_sel_n, l_ce_n, l_wr, l_rd, r_sel_n, r_ce_n, r_wr, r_rd;
    logic [ADDR_W-1:0] l_addr, r_addr;
    logic [DATA_W-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
    int tests = 0;
    int fails = 0;
    logic [DATA_W-1:0] got_l, got_r;

    always #(CLK_PERIOD/2) clk = ~clk;

    sem_token_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sem_token_unit (
        .clk(clk), .rst_n(rst_n),
        .l_sel_n(l_sel_n), .l_ce_n(l_ce_n), .l_wr(l_wr), .l_rd(l_rd),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_sel_n(r_sel_n), .r_ce_n(r_ce_n), .r_wr(r_wr), .r_rd(r_rd),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        l_sel_n = 1'b1; l_ce_n = 1'b1; l_wr = 1'b0; l_rd = 1'b0;
        r_sel_n = 1'b1; r_ce_n = 1'b1; r_wr = 1'b0; r_rd = 1'b0;
        l_addr = '0; r_addr = '0; l_wdata = '0; r_wdata = '0;
    endtask

    task automatic check(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // side 0 = left, 1 = right; legal token write, one cycle
    task automatic wr_tok(int side, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
        if (side == 0) begin
            l_sel_n = 1'b0; l_wr = 1'b1; l_addr = a; l_wdata = d;
        end else begin
            r_sel_n = 1'b0; r_wr = 1'b1; r_addr = a; r_wdata = d;
        end
        tick();
        idle();
    endtask

    // both ports read the same token in one cycle
    task automatic rd_both(logic [ADDR_W-1:0] a);
        l_sel_n = 1'b0; l_rd = 1'b1; l_addr = a;
        r_sel_n = 1'b0; r_rd = 1'b1; r_addr = a;
        tick();
        idle();
        got_l = l_rdata;
        got_r = r_rdata;
    endtask

    task automatic t_reset();
        check("R1 left rdata", l_rdata, ONES);
        check("R1 right rdata", r_rdata, ONES);
        for (int i = 0; i < 8; i++) begin
            rd_both(ADDR_W'(i));
            check("R1 R5 R11 free left", got_l, ONES);
            check("R1 R5 R11 free right", got_r, ONES);
        end
    endtask

    task automatic t_take_and_block();
        wr_tok(0, 2, ZERO);
        rd_both(2);
        check("R5 owner reads 0", got_l, ZERO);
        check("R5 other reads 1", got_r, ONES);
        rd_both(3);
        check("R11 neighbour free", got_l & got_r, ONES);
        wr_tok(1, 2, ZERO);
        rd_both(2);
        check("R6 nonowner req left", got_l, ZERO);
        check("R6 nonowner req right", got_r, ONES);
        wr_tok(1, 2, 16'h0001);
        rd_both(2);
        check("R6 nonowner release right", got_r, ONES);
        check("R6 nonowner release left", got_l, ZERO);
        wr_tok(0, 2, 16'h0001);
        rd_both(2);
        check("R8 cancelled then freed", got_l & got_r, ONES);
    endtask

    task automatic t_wait_grant();
        wr_tok(0, 5, ZERO);
        wr_tok(1, 5, ZERO);
        wr_tok(0, 5, 16'h0001);
        rd_both(5);
        check("R7 waiting right granted", got_r, ZERO);
        check("R7 left released", got_l, ONES);
        wr_tok(1, 5, 16'h0001);
        rd_both(5);
        check("R7 freed after right release", got_l & got_r, ONES);
    endtask

    task automatic t_joint_request();
        l_sel_n = 1'b0; l_wr = 1'b1; l_addr = 6; l_wdata = ZERO;
        r_sel_n = 1'b0; r_wr = 1'b1; r_addr = 6; r_wdata = ZERO;
        tick();
        idle();
        rd_both(6);
        check("R9 left wins", got_l, ZERO);
        check("R9 right loses", got_r, ONES);
        wr_tok(0, 6, 16'h0001);
        rd_both(6);
        check("R9 right request kept", got_r, ZERO);
        wr_tok(1, 6, 16'h0001);
    endtask

    task automatic t_addr_data_bits();
        wr_tok(0, 14'h3FF9, 16'h0001);
        wr_tok(0, 14'h3FF9, 16'hFFFE);
        rd_both(1);
        check("R3 upper address ignored", got_l, ZERO);
        check("R4 only bit0 used request", got_r, ONES);
        wr_tok(0, 14'h0101, 16'h8001);
        rd_both(1);
        check("R4 R3 release", got_l & got_r, ONES);
    endtask

    task automatic t_illegal_select();
        l_sel_n = 1'b0; l_ce_n = 1'b0; l_wr = 1'b1; l_addr = 7; l_wdata = ZERO;
        tick();
        idle();
        l_sel_n = 1'b1; l_ce_n = 1'b1; l_wr = 1'b1; l_addr = 7; l_wdata = ZERO;
        tick();
        idle();
        rd_both(7);
        check("R2 illegal writes ignored", got_l & got_r, ONES);
        wr_tok(0, 0, ZERO);
        rd_both(0);
        check("R2 setup left owns 0", got_l, ZERO);
        l_sel_n = 1'b0; l_ce_n = 1'b0; l_rd = 1'b1; l_addr = 7;
        tick();
        idle();
        check("R2 illegal read no capture", l_rdata, ZERO);
        wr_tok(0, 0, 16'h0001);
    endtask

    task automatic t_read_during_write();
        wr_tok(0, 0, ZERO);
        wr_tok(1, 0, ZERO);
        l_sel_n = 1'b0; l_wr = 1'b1; l_addr = 0; l_wdata = 16'h0001;
        r_sel_n = 1'b0; r_rd = 1'b1; r_addr = 0;
        tick();
        idle();
        check("R10 captured pre-write view", r_rdata, ONES);
        rd_both(0);
        check("R10 next read shows grant", got_r, ZERO);
        for (int i = 0; i < 4; i++) tick();
        check("R10 held while idle", r_rdata, ZERO);
        wr_tok(1, 0, 16'h0001);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual hang expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        idle();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_take_and_block();
        t_wait_grant();
        t_joint_request();
        t_addr_data_bits();
        t_illegal_select();
        t_read_during_write();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule